// File: doc/BRIEF.md
# Master Volume Event Updater

This block services a hardware volume-button event. When an interrupt is accepted, it takes a snapshot of a packed counter byte and of the current stereo master volume shadow. It masks the undefined counter bits and decodes the snapshot as one of four actions: a mute toggle, a one-step volume up, a one-step volume down, or nothing. It then produces the updated shadow value.

The volume word holds two 7-bit attenuation fields, one per channel, in bits 6:0 and bits 14:8. Bit 15 is the mute flag. Bit 7 carries no meaning here and is passed through. A smaller attenuation is louder, so volume up reduces each field and volume down raises it. Every event resets the counters by issuing a reset strobe. Every event that changes the volume also issues a codec write strobe that carries the new word. The serial link to the codec lies outside this block.

Top module: `hw_vol_updater`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `vol_o`, `codec_data_o`, `codec_we_o` and `cnt_rst_o` are all zero.
- R2: The counter byte is ANDed with 0xEE before it is decoded. This means 0x99 decodes the same as 0x88, 0xBB the same as 0xAA, 0x77 the same as 0x66, and 0xFF as 0xEE.
- R3: A masked value of 0x88 means mute. The new word equals the old word with bit 15 inverted and all other bits kept.
- R4: A masked value of 0xAA means volume up. Each field (bits 6:0 and bits 14:8) goes down by one if it is nonzero. A field that is zero stays zero.
- R5: A masked value of 0x66 means volume down. Each field goes up by one if it is below 0x1F. A field at 0x1F or above stays as it is.
- R6: On volume up and volume down, bit 15 and bit 7 stay unchanged.
- R7: Timing of the counter reset:
  - Edge E0 is the rising edge that accepts `irq_i`. `cnt_byte_i` and `vol_i` are sampled at edge E0+1.
  - `cnt_rst_o` goes high after edge E0+2 and stays high for exactly one cycle, for every event.
  - While it is high, `cnt_rst_data_o` is 0x88.
- R8: `vol_o` shows the new word from edge E0+2 onward. For mute, up and down, `codec_we_o` is high for exactly one cycle after edge E0+3, with `codec_data_o` equal to the new word.
- R9: Any other masked value leaves the word unchanged, so `vol_o` equals the sampled `vol_i`. No codec write is issued, but the counter reset pulse is still produced.
- R10: An `irq_i` that is high while an event is in progress (edges E0+1 to E0+3) is ignored. It produces no second reset pulse and no second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Volume-button interrupt request |
| cnt_byte_i | input | 8 | Packed counter snapshot |
| vol_i | input | 16 | Current master volume shadow |
| vol_o | output | 16 | Updated master volume shadow |
| codec_we_o | output | 1 | Codec write strobe, one cycle |
| codec_data_o | output | 16 | Codec write data |
| cnt_rst_o | output | 1 | Counter reset strobe, one cycle |
| cnt_rst_data_o | output | 8 | Value written to the counters on reset |

## Verification
Each result appears at a fixed cycle after the accepting edge E0:
- The counter reset strobe and the new `vol_o` appear after E0+2.
- The codec write appears after E0+3.
- Both strobes must be low again after E0+4.

The bench drives `irq_i` at a falling edge and then counts rising edges. It samples each output at the falling edge that follows its due edge, checks that edge and the ones on either side, and never polls for a result. The busy case holds `irq_i` high across E0 to E0+3 and counts the strobes over the whole window.

// File: rtl/hvu_pkg.sv
package hvu_pkg;
  typedef enum logic [1:0] {ACT_NONE, ACT_MUTE, ACT_UP, ACT_DN} act_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_UPDATE, ST_WRITE} st_e;
endpackage

// File: rtl/hvu_decode.sv
module hvu_decode
  import hvu_pkg::*;
#(
  parameter int          CNT_W     = 8,
  parameter logic [CNT_W-1:0] CNT_MASK  = 8'hEE,
  parameter logic [CNT_W-1:0] CODE_MUTE = 8'h88,
  parameter logic [CNT_W-1:0] CODE_UP   = 8'hAA,
  parameter logic [CNT_W-1:0] CODE_DN   = 8'h66
) (
  input  logic [CNT_W-1:0] cnt_i,
  output act_e             act_o
);
  logic [CNT_W-1:0] masked;
  assign masked = cnt_i & CNT_MASK;

  always_comb begin
    if (masked == CODE_MUTE)    act_o = ACT_MUTE;
    else if (masked == CODE_UP) act_o = ACT_UP;
    else if (masked == CODE_DN) act_o = ACT_DN;
    else                        act_o = ACT_NONE;
  end
endmodule

// File: rtl/hvu_step.sv
module hvu_step
  import hvu_pkg::*;
#(
  parameter int              VOL_W     = 16,
  parameter int              NCH       = 2,
  parameter int              CH_W      = 7,
  parameter int              CH_STRIDE = 8,
  parameter int              MUTE_BIT  = 15,
  parameter logic [CH_W-1:0] ATT_MAX   = 7'h1F
) (
  input  logic [VOL_W-1:0] vol_i,
  input  act_e             act_i,
  output logic [VOL_W-1:0] vol_o
);
  logic [CH_W-1:0] fld_next [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CH_W-1:0] fld;
    assign fld = vol_i[c*CH_STRIDE +: CH_W];
    always_comb begin
      unique case (act_i)
        ACT_UP:  fld_next[c] = (fld != '0)     ? fld - CH_W'(1) : fld;
        ACT_DN:  fld_next[c] = (fld < ATT_MAX) ? fld + CH_W'(1) : fld;
        default: fld_next[c] = fld;
      endcase
    end
  end

  always_comb begin
    vol_o = vol_i;
    if (act_i == ACT_MUTE) vol_o[MUTE_BIT] = ~vol_i[MUTE_BIT];
    for (int c = 0; c < NCH; c++) vol_o[c*CH_STRIDE +: CH_W] = fld_next[c];
  end
endmodule

// File: rtl/hw_vol_updater.sv
module hw_vol_updater
  import hvu_pkg::*;
#(
  parameter int              VOL_W     = 16,
  parameter int              CNT_W     = 8,
  parameter int              NCH       = 2,
  parameter int              CH_W      = 7,
  parameter int              CH_STRIDE = 8,
  parameter int              MUTE_BIT  = 15,
  parameter logic [CH_W-1:0] ATT_MAX   = 7'h1F,
  parameter logic [CNT_W-1:0] CNT_MASK  = 8'hEE,
  parameter logic [CNT_W-1:0] CODE_MUTE = 8'h88,
  parameter logic [CNT_W-1:0] CODE_UP   = 8'hAA,
  parameter logic [CNT_W-1:0] CODE_DN   = 8'h66,
  parameter logic [CNT_W-1:0] RST_CODE  = 8'h88
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_i,
  input  logic [7:0]       cnt_byte_i,
  input  logic [15:0]      vol_i,
  output logic [15:0]      vol_o,
  output logic             codec_we_o,
  output logic [15:0]      codec_data_o,
  output logic             cnt_rst_o,
  output logic [7:0]       cnt_rst_data_o
);
  st_e              state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [VOL_W-1:0] vol_q;
  logic [VOL_W-1:0] vol_next;
  act_e             act_d, act_q;

  hvu_decode #(
    .CNT_W(CNT_W), .CNT_MASK(CNT_MASK), .CODE_MUTE(CODE_MUTE),
    .CODE_UP(CODE_UP), .CODE_DN(CODE_DN)
  ) u_dec (
    .cnt_i (cnt_q),
    .act_o (act_d)
  );

  hvu_step #(
    .VOL_W(VOL_W), .NCH(NCH), .CH_W(CH_W), .CH_STRIDE(CH_STRIDE),
    .MUTE_BIT(MUTE_BIT), .ATT_MAX(ATT_MAX)
  ) u_step (
    .vol_i (vol_q),
    .act_i (act_d),
    .vol_o (vol_next)
  );

  assign cnt_rst_data_o = RST_CODE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      vol_q        <= '0;
      act_q        <= ACT_NONE;
      vol_o        <= '0;
      codec_we_o   <= 1'b0;
      codec_data_o <= '0;
      cnt_rst_o    <= 1'b0;
    end else begin
      cnt_rst_o  <= 1'b0;
      codec_we_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (irq_i) state_q <= ST_SAMPLE;
        ST_SAMPLE: begin
          cnt_q   <= cnt_byte_i;
          vol_q   <= vol_i;
          state_q <= ST_UPDATE;
        end
        ST_UPDATE: begin
          vol_o     <= vol_next;
          act_q     <= act_d;
          cnt_rst_o <= 1'b1;
          state_q   <= ST_WRITE;
        end
        ST_WRITE: begin
          codec_we_o   <= (act_q != ACT_NONE);
          codec_data_o <= vol_o;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: reset strobe is a single-cycle pulse
  assert_rst_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_o |=> !cnt_rst_o);

  // R8: codec write trails the counter reset by one cycle and carries the shadow
  assert_we_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    codec_we_o |-> ($past(cnt_rst_o) && codec_data_o == vol_o));

  // R9: no write for an unknown code
  assert_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_o && act_q == ACT_NONE) |=> !codec_we_o);

  // R6: mute flag kept on steps
  assert_mute_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_o && (act_q == ACT_UP || act_q == ACT_DN)) |-> vol_o[MUTE_BIT] == vol_q[MUTE_BIT]);

  // R3: mute flips the flag
  assert_mute_flip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_o && act_q == ACT_MUTE) |-> vol_o[MUTE_BIT] != vol_q[MUTE_BIT]);

  // R10: no new event accepted while busy
  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q != ST_SAMPLE));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [CH_W-1:0] old_f, new_f;
    assign old_f = vol_q[c*CH_STRIDE +: CH_W];
    assign new_f = vol_o[c*CH_STRIDE +: CH_W];
    // R4: up moves a field down by at most one
    assert_up_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_rst_o && act_q == ACT_UP) |-> (new_f <= old_f && (old_f - new_f) <= CH_W'(1)));
    // R5: down never pushes a field past the limit
    assert_dn_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_rst_o && act_q == ACT_DN) |-> (new_f == old_f || new_f <= ATT_MAX));
  end
endmodule

// File: tb/sim_hw_vol_updater.sv
`timescale 1ns/1ps
module sim_hw_vol_updater;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq = 1'b0;
  logic [7:0]  cnt = '0;
  logic [15:0] vin = '0;
  logic [15:0] vol_o, codec_data;
  logic        codec_we, cnt_rst;
  logic [7:0]  cnt_rst_data;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  hw_vol_updater u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .cnt_byte_i(cnt), .vol_i(vin),
    .vol_o(vol_o), .codec_we_o(codec_we), .codec_data_o(codec_data),
    .cnt_rst_o(cnt_rst), .cnt_rst_data_o(cnt_rst_data)
  );

  // {cnt_byte, vol_in, expected, write_expected}
  localparam int NV = 12;
  localparam logic [40:0] VEC [NV] = '{
    {8'h88, 16'h0808, 16'h8808, 1'b1},  // R3 mute set
    {8'h99, 16'h8000, 16'h0000, 1'b1},  // R2 R3 masked mute clear
    {8'hAA, 16'h0A05, 16'h0904, 1'b1},  // R4 up
    {8'hBB, 16'h0100, 16'h0000, 1'b1},  // R2 R4 zero floor
    {8'h66, 16'h1E10, 16'h1F11, 1'b1},  // R5 down
    {8'h77, 16'h1F1F, 16'h1F1F, 1'b1},  // R2 R5 cap
    {8'h66, 16'h8080, 16'h8181, 1'b1},  // R6 flags kept on down
    {8'hAA, 16'h807F, 16'h807E, 1'b1},  // R6 R4 flags kept on up
    {8'h66, 16'h4020, 16'h4020, 1'b1},  // R5 above cap stays
    {8'h00, 16'h1234, 16'h1234, 1'b0},  // R9 unknown
    {8'hFF, 16'hABCD, 16'hABCD, 1'b0},  // R2 R9 0xEE unknown
    {8'h2A, 16'h5A5A, 16'h5A5A, 1'b0}   // R9 unknown
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_event(input logic [7:0] c, input logic [15:0] v,
                           input logic [15:0] e, input logic we_e, input int idx);
    @(negedge clk); cnt = c; vin = v; irq = 1'b1;
    @(posedge clk);                       // E0
    @(negedge clk); irq = 1'b0;
    @(posedge clk);                       // E0+1 sample
    @(posedge clk);                       // E0+2
    @(negedge clk);
    chk($sformatf("R7 rst pulse vec %0d", idx), 32'(cnt_rst), 32'd1);
    chk($sformatf("R7 rst data vec %0d", idx), 32'(cnt_rst_data), 32'h88);
    chk($sformatf("R3/R4/R5/R6/R9 vol vec %0d", idx), 32'(vol_o), 32'(e));
    chk($sformatf("R8 early we vec %0d", idx), 32'(codec_we), 32'd0);
    @(posedge clk);                       // E0+3
    @(negedge clk);
    chk($sformatf("R8/R9 we vec %0d", idx), 32'(codec_we), 32'(we_e));
    if (we_e) chk($sformatf("R8 data vec %0d", idx), 32'(codec_data), 32'(e));
    chk($sformatf("R7 rst low vec %0d", idx), 32'(cnt_rst), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk($sformatf("R8 we low vec %0d", idx), 32'(codec_we), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n_rst, n_we;
    repeat (3) @(negedge clk);
    chk("R1 vol in reset", 32'(vol_o), 32'd0);
    chk("R1 strobes in reset", {30'd0, codec_we, cnt_rst}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 data after reset", 32'(codec_data), 32'd0);

    for (int i = 0; i < NV; i++)
      run_event(VEC[i][40:33], VEC[i][32:17], VEC[i][16:1], VEC[i][0], i);

    // R10: irq held high through busy window
    n_rst = 0; n_we = 0;
    @(negedge clk); cnt = 8'h88; vin = 16'h0000; irq = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      n_rst += int'(cnt_rst); n_we += int'(codec_we);
    end
    irq = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); @(negedge clk);
      n_rst += int'(cnt_rst); n_we += int'(codec_we);
    end
    chk("R10 single reset pulse", 32'(n_rst), 32'd1);
    chk("R10 single write", 32'(n_we), 32'd1);
    chk("R10 vol after busy", 32'(vol_o), 32'h8000);

    // R1: reset clears a nonzero shadow
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 vol cleared", 32'(vol_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule